// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Operands

This block is the execute step of a small 32-bit load/store integer core. The decoder supplies an operation code, two register operands, a 16-bit immediate, a 5-bit shift count and a bit that selects the immediate in place of the second register. The block computes one 32-bit result. Each operation extends the immediate in its own way. There are no status flags. A comparison returns the value 0 or 1 as its result.

Operations enter and leave on valid/ready streams, and one register stage sits between the two streams. The input side accepts an operation in a cycle where `in_valid` and `in_ready` are both high. The result is presented with `out_valid` on the next cycle. The result stays on the output until the consumer takes it with `out_ready`. Back-pressure passes straight through: `in_ready` is high when the output register is empty or is being emptied in that same cycle. A full pipe can therefore accept a new operation in the cycle where the consumer takes the old result. The producer must hold its inputs steady while `in_valid` is high and `in_ready` is low.

Top module: `xu_exec`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts (first operand minus second). Both wrap modulo 2^32 and never trap. When `in_imm_sel` is 1, the second operand is the sign-extended immediate.
- R2: Opcodes 2, 3, 4 and 5 produce the bitwise AND, OR, XOR and NOR of the two operands. When `in_imm_sel` is 1, the second operand is the zero-extended immediate. NOR of a register with itself inverts that register.
- R3: Opcode 6 shifts `in_rs` left and opcode 7 shifts it right, both filling with zeros. Opcode 8 shifts it right and copies the sign bit into the vacated positions. The shift count is `in_shamt` (0 to 31), and a count of 0 returns `in_rs` unchanged. `in_rt`, `in_imm` and `in_imm_sel` have no effect on shifts.
- R4: Opcode 9 returns 1 when the first operand is less than the second as signed numbers. Opcode 10 does the same comparison as unsigned numbers. Otherwise both return 0, and bits 31:1 of a comparison result are always 0.
- R5: With `in_imm_sel` at 1, opcode 9 compares against the sign-extended immediate and opcode 10 compares against the zero-extended immediate.
- R6: Opcodes 11 to 15 are undefined and give a result of zero.
- R7: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. On the next cycle `out_valid` is high and `out_result` holds its result. `in_ready` is low only while `out_valid` is high and `out_ready` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` does not change.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation |
| in_op | input | 4 | Operation code |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Shift count |
| in_imm_sel | input | 1 | Use the immediate as the second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Computed result |

## Verification
The properties watch the stream protocol on every cycle. Every accepted operation must show up one cycle later. A stalled result must keep both its value and its valid. `in_ready` must drop while the output is blocked. On each cycle they also check two things about results: a comparison result is only ever 0 or 1, and an undefined opcode or a shift by zero produces the expected value. Whether each operation computes the right value, and in particular which extension each immediate form uses, shows only in the bench's vector walk. The bench chooses operand pairs for which the wrong extension or the wrong signedness gives a different answer.

// File: rtl/xu_pkg.sv
package xu_pkg;
  localparam int XLEN  = 32;
  localparam int IMMW  = 16;
  localparam int SHW   = $clog2(XLEN);
  localparam int OPW   = 4;

  typedef enum logic [OPW-1:0] {
    XU_ADD  = 4'd0,
    XU_SUB  = 4'd1,
    XU_AND  = 4'd2,
    XU_OR   = 4'd3,
    XU_XOR  = 4'd4,
    XU_NOR  = 4'd5,
    XU_SHL  = 4'd6,
    XU_SHRL = 4'd7,
    XU_SHRA = 4'd8,
    XU_LTS  = 4'd9,
    XU_LTU  = 4'd10
  } xu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN,
    EXT_ZERO
  } ext_kind_e;
endpackage

// File: rtl/xu_opnd.sv
module xu_opnd
  import xu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMMW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   rt,
  input  logic [IW-1:0]  imm,
  input  logic           imm_sel,
  output logic [W-1:0]   opnd_b
);
  localparam int PADW = W - IW;

  ext_kind_e kind;
  logic [W-1:0] imm_ext;

  always_comb begin
    case (op)
      XU_ADD, XU_SUB, XU_LTS: kind = EXT_SIGN;
      default:                kind = EXT_ZERO;
    endcase
  end

  always_comb begin
    if (kind == EXT_SIGN) imm_ext = {{PADW{imm[IW-1]}}, imm};
    else                  imm_ext = {{PADW{1'b0}}, imm};
  end

  assign opnd_b = imm_sel ? imm_ext : rt;
endmodule

// File: rtl/xu_calc.sv
module xu_calc
  import xu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SW = SHW
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  shamt,
  output logic [W-1:0]   res
);
  logic [W-1:0] sum, diff, shl, shrl, shra;
  logic         lt_s, lt_u;

  assign sum  = a + b;
  assign diff = a - b;
  assign shl  = a << shamt;
  assign shrl = a >> shamt;
  assign shra = W'($signed(a) >>> shamt);
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    case (op)
      XU_ADD:  res = sum;
      XU_SUB:  res = diff;
      XU_AND:  res = a & b;
      XU_OR:   res = a | b;
      XU_XOR:  res = a ^ b;
      XU_NOR:  res = ~(a | b);
      XU_SHL:  res = shl;
      XU_SHRL: res = shrl;
      XU_SHRA: res = shra;
      XU_LTS:  res = {{(W-1){1'b0}}, lt_s};
      XU_LTU:  res = {{(W-1){1'b0}}, lt_u};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/xu_stage.sv
module xu_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)             full_q <= 1'b0;
    else if (take)          full_q <= 1'b1;
    else if (dn_ready)      full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (take) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/xu_exec.sv
module xu_exec
  import xu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_op,
  input  logic [XLEN-1:0]  in_rs,
  input  logic [XLEN-1:0]  in_rt,
  input  logic [IMMW-1:0]  in_imm,
  input  logic [SHW-1:0]   in_shamt,
  input  logic             in_imm_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result
);
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] calc_res;

  xu_opnd #(.W(XLEN), .IW(IMMW)) u_opnd (
    .op(in_op), .rt(in_rt), .imm(in_imm), .imm_sel(in_imm_sel), .opnd_b(opnd_b)
  );

  xu_calc #(.W(XLEN), .SW(SHW)) u_calc (
    .op(in_op), .a(in_rs), .b(opnd_b), .shamt(in_shamt), .res(calc_res)
  );

  xu_stage #(.W(XLEN)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(calc_res),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_result)
  );
endmodule

// File: rtl/xu_exec_chk.sv
module xu_exec_chk
  import xu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OPW-1:0]   in_op,
  input logic [XLEN-1:0]  in_rs,
  input logic [SHW-1:0]   in_shamt,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_result
);
  logic [OPW-1:0]  c_op;
  logic [XLEN-1:0] c_rs;
  logic [SHW-1:0]  c_sh;

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      c_op <= in_op;
      c_rs <= in_rs;
      c_sh <= in_shamt;
    end
  end

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result));

  p_bool_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (c_op == XU_LTS || c_op == XU_LTU) |-> out_result[XLEN-1:1] == '0);

  p_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c_op > XU_LTU |-> out_result == '0);

  p_shift0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (c_op == XU_SHL || c_op == XU_SHRL || c_op == XU_SHRA) && c_sh == '0
      |-> out_result == c_rs);
endmodule

bind xu_exec xu_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_rs(in_rs), .in_shamt(in_shamt),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
);

// File: tb/test_xu_exec.sv
module test_xu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_rs = '0;
  logic [31:0] in_rt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        in_imm_sel = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xu_exec i_xu_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .in_shamt(in_shamt), .in_imm_sel(in_imm_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  // entry: op(4) sel(1) rs(32) rt(32) imm(16) shamt(5) expected(32)
  localparam int NV = 24;
  localparam logic [121:0] VEC [NV] = '{
    {4'd0,  1'b0, 32'h00000007, 32'h00000005, 16'h0000, 5'd0,  32'h0000000C}, // R1 add
    {4'd0,  1'b0, 32'hFFFFFFFF, 32'h00000002, 16'h0000, 5'd0,  32'h00000001}, // R1 wrap
    {4'd0,  1'b1, 32'h0000000A, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000009}, // R1 addi sext
    {4'd0,  1'b1, 32'h00000000, 32'h12345678, 16'h8000, 5'd0,  32'hFFFF8000}, // R1 addi sext
    {4'd1,  1'b0, 32'h00000003, 32'h00000005, 16'h0000, 5'd0,  32'hFFFFFFFE}, // R1 sub
    {4'd1,  1'b1, 32'h00000000, 32'h00000000, 16'h8000, 5'd0,  32'h00008000}, // R1 subi
    {4'd2,  1'b1, 32'hFFFFFFFF, 32'h00000000, 16'h8001, 5'd0,  32'h00008001}, // R2 andi zext
    {4'd3,  1'b1, 32'h12340000, 32'hFFFFFFFF, 16'hF00F, 5'd0,  32'h1234F00F}, // R2 ori
    {4'd4,  1'b0, 32'hFF00FF00, 32'h0F0F0F0F, 16'h0000, 5'd0,  32'hF00FF00F}, // R2 xor
    {4'd4,  1'b1, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF, 5'd0,  32'hFFFF0000}, // R2 xori
    {4'd5,  1'b0, 32'hA5A5A5A5, 32'hA5A5A5A5, 16'h0000, 5'd0,  32'h5A5A5A5A}, // R2 nor=not
    {4'd2,  1'b0, 32'hF0F0F0F0, 32'h3C3C3C3C, 16'h0000, 5'd0,  32'h30303030}, // R2 and
    {4'd6,  1'b0, 32'h00000001, 32'h00000000, 16'h0000, 5'd31, 32'h80000000}, // R3 shl
    {4'd7,  1'b0, 32'h80000000, 32'h00000000, 16'h0000, 5'd4,  32'h08000000}, // R3 shrl
    {4'd8,  1'b0, 32'h80000000, 32'h00000000, 16'h0000, 5'd4,  32'hF8000000}, // R3 shra
    {4'd8,  1'b0, 32'h80000001, 32'h00000000, 16'h0000, 5'd0,  32'h80000001}, // R3 zero count
    {4'd6,  1'b1, 32'h000000FF, 32'h00000123, 16'hFFFF, 5'd8,  32'h0000FF00}, // R3 imm ignored
    {4'd9,  1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001}, // R4 signed
    {4'd10, 1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000}, // R4 unsigned
    {4'd9,  1'b0, 32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000}, // R4 equal
    {4'd9,  1'b1, 32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001}, // R5 sext imm
    {4'd10, 1'b1, 32'h00010000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000000}, // R5 zext imm
    {4'd11, 1'b0, 32'h00000001, 32'h00000001, 16'h0001, 5'd1,  32'h00000000}, // R6
    {4'd15, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd3,  32'h00000000}  // R6
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op, input logic sel);
    if (op <= 4'd1)  return "R1";
    if (op <= 4'd5)  return "R2";
    if (op <= 4'd8)  return "R3";
    if (op <= 4'd10) return sel ? "R5" : "R4";
    return "R6";
  endfunction

  task automatic drive(input logic [121:0] v);
    {in_op, in_imm_sel, in_rs, in_rt, in_imm, in_shamt} = v[121:32];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({31'd0, out_valid}, 32'd0, "R9 out_valid after reset");
    check({31'd0, in_ready}, 32'd1, "R9 in_ready after reset");
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({31'd0, out_valid}, 32'd1, "R7 valid one cycle after accept");
      check(out_result, VEC[i][31:0], req_of(VEC[i][121:118], VEC[i][117]));
    end

    // back-pressure: result held, ready low, then simultaneous drain and accept
    @(negedge clk);
    out_ready = 1'b0;
    drive({4'd0, 1'b0, 32'h00000100, 32'h00000023, 16'h0, 5'd0, 32'h0});
    in_valid = 1'b1;
    @(negedge clk);
    drive({4'd1, 1'b0, 32'h00000050, 32'h00000010, 16'h0, 5'd0, 32'h0});
    check({31'd0, in_ready}, 32'd0, "R7 ready low while stalled");
    repeat (3) @(negedge clk);
    check({31'd0, out_valid}, 32'd1, "R8 valid held");
    check(out_result, 32'h00000123, "R8 result held");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({31'd0, out_valid}, 32'd1, "R7 refill on drain");
    check(out_result, 32'h00000040, "R7 second result");
    @(negedge clk);
    check({31'd0, out_valid}, 32'd0, "R7 empty after drain");

    // reset in the middle of traffic clears the output
    drive({4'd0, 1'b0, 32'h1, 32'h1, 16'h0, 5'd0, 32'h0});
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check({31'd0, out_valid}, 32'd0, "R9 reset clears valid");
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule